// File: doc/BRIEF.md
# Dual-Write-Port Register File

This block holds the general-purpose registers of a single-cycle processor: fifteen 64-bit registers, selected by 4-bit IDs 0x0 through 0xE. ID 0x4 is the register that software uses as its stack pointer, but the storage treats it like every other entry. ID 0xF is reserved as the null ID and names no register.

Two read ports return operands with no clock in between: the data output follows the read ID within the same cycle. Two write ports each take a destination ID and a data word. Both commit on the same rising clock edge, so one instruction can retire two results at once. A write port given the null ID writes nothing. When both write ports name the same register in one cycle, the value from write port B is the one stored. A synchronous reset clears every register.

Top module: `dual_wr_regfile`

## Requirements
- R1: While `rst` is high at a rising clock edge, every register is set to zero at that edge. Any write presented in that cycle is discarded.
- R2: Each read port is combinational. Its data output shows the stored value of the register named by its read ID in the same cycle, and both ports give the same value when they name the same ID.
- R3: A read ID of 0xF produces zero on that port's data output.
- R4: A write on port A with an ID from 0x0 to 0xE changes that register at the next rising edge. Reads before that edge return the old value. Reads after it return the new value.
- R5: Write port B behaves like port A and works independently of it. Two writes to different registers in the same cycle both take effect at the same edge.
- R6: A write port given ID 0xF changes no register.
- R7: If both write ports name the same non-null register in the same cycle, port B's data is stored and port A's data is dropped.
- R8: A write changes only the register it names. All other registers keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all writes commit on its rising edge |
| rst | input | 1 | Synchronous active-high reset, clears all registers |
| rd_id_a | input | 4 | Read port A register ID (0xF = null) |
| rd_data_a | output | 64 | Read port A data |
| rd_id_b | input | 4 | Read port B register ID (0xF = null) |
| rd_data_b | output | 64 | Read port B data |
| wr_id_a | input | 4 | Write port A destination ID (0xF = no write) |
| wr_data_a | input | 64 | Write port A data |
| wr_id_b | input | 4 | Write port B destination ID (0xF = no write) |
| wr_data_b | input | 64 | Write port B data |

## Verification
The hardest case to reach from the ports is a same-cycle collision of the two write ports, together with its neighbours: one port null while the other writes, both ports null, and two different targets. The bench sweeps every ordered pair of write IDs, all 256 of them including 0xF. Each cycle carries data built from the IDs and a running count, so a dropped or swapped write shows up as a wrong value. After each edge the bench reads back both targets, and it sweeps the whole file at intervals to catch stray writes. A reset issued while writes are pending confirms that those writes are discarded.

// File: rtl/rf_pkg.sv
package rf_pkg;
    // Default geometry of the register file
    localparam int RF_DATA_W = 64;
    localparam int RF_ID_W   = 4;

    // Which write port a storage entry took its value from in a cycle
    typedef enum logic [1:0] {
        WSRC_HOLD  = 2'b00,
        WSRC_PORTA = 2'b01,
        WSRC_PORTB = 2'b10
    } wsrc_e;
endpackage

// File: rtl/rf_wr_decode.sv
module rf_wr_decode #(
    parameter int ID_W     = rf_pkg::RF_ID_W,
    localparam int NUM_REGS = (1 << ID_W) - 1
) (
    input  logic [ID_W-1:0]     wr_id,
    output logic [NUM_REGS-1:0] wr_sel
);
    // One-hot select; the all-ones ID maps to no entry
    always_comb begin
        wr_sel = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (wr_id == ID_W'(i)) wr_sel[i] = 1'b1;
        end
    end
endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
    parameter int DATA_W   = rf_pkg::RF_DATA_W,
    parameter int ID_W     = rf_pkg::RF_ID_W,
    localparam int NUM_REGS = (1 << ID_W) - 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_REGS-1:0] sel_a,
    input  logic [DATA_W-1:0]   data_a,
    input  logic [NUM_REGS-1:0] sel_b,
    input  logic [DATA_W-1:0]   data_b,
    output logic [DATA_W-1:0]   regs [NUM_REGS]
);
    import rf_pkg::*;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_entry
        wsrc_e src;

        // Port B has priority over port A on a shared target
        always_comb begin
            unique case ({sel_b[g], sel_a[g]})
                2'b00:          src = WSRC_HOLD;
                2'b01:          src = WSRC_PORTA;
                2'b10, 2'b11:   src = WSRC_PORTB;
                default:        src = WSRC_HOLD;
            endcase
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= '0;
            end else begin
                unique case (src)
                    WSRC_PORTA: regs[g] <= data_a;
                    WSRC_PORTB: regs[g] <= data_b;
                    default:    regs[g] <= regs[g];
                endcase
            end
        end
    end
endmodule

// File: rtl/rf_read_mux.sv
module rf_read_mux #(
    parameter int DATA_W   = rf_pkg::RF_DATA_W,
    parameter int ID_W     = rf_pkg::RF_ID_W,
    localparam int NUM_REGS = (1 << ID_W) - 1
) (
    input  logic [DATA_W-1:0] regs [NUM_REGS],
    input  logic [ID_W-1:0]   rd_id,
    output logic [DATA_W-1:0] rd_data
);
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_id == ID_W'(i)) rd_data = regs[i];
        end
    end
endmodule

// File: rtl/dual_wr_regfile.sv
module dual_wr_regfile #(
    parameter int DATA_W = rf_pkg::RF_DATA_W,
    parameter int ID_W   = rf_pkg::RF_ID_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ID_W-1:0]   rd_id_a,
    output logic [DATA_W-1:0] rd_data_a,
    input  logic [ID_W-1:0]   rd_id_b,
    output logic [DATA_W-1:0] rd_data_b,
    input  logic [ID_W-1:0]   wr_id_a,
    input  logic [DATA_W-1:0] wr_data_a,
    input  logic [ID_W-1:0]   wr_id_b,
    input  logic [DATA_W-1:0] wr_data_b
);
    localparam int NUM_REGS = (1 << ID_W) - 1;
    localparam int NUM_RD   = 2;

    logic [NUM_REGS-1:0] sel_a, sel_b;
    logic [DATA_W-1:0]   regs [NUM_REGS];
    logic [ID_W-1:0]     rd_id   [NUM_RD];
    logic [DATA_W-1:0]   rd_data [NUM_RD];

    rf_wr_decode #(.ID_W(ID_W)) u_dec_a (.wr_id(wr_id_a), .wr_sel(sel_a));
    rf_wr_decode #(.ID_W(ID_W)) u_dec_b (.wr_id(wr_id_b), .wr_sel(sel_b));

    rf_storage #(.DATA_W(DATA_W), .ID_W(ID_W)) u_store (
        .clk    (clk),
        .rst    (rst),
        .sel_a  (sel_a),
        .data_a (wr_data_a),
        .sel_b  (sel_b),
        .data_b (wr_data_b),
        .regs   (regs)
    );

    assign rd_id[0] = rd_id_a;
    assign rd_id[1] = rd_id_b;

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        rf_read_mux #(.DATA_W(DATA_W), .ID_W(ID_W)) u_mux (
            .regs    (regs),
            .rd_id   (rd_id[p]),
            .rd_data (rd_data[p])
        );
    end

    assign rd_data_a = rd_data[0];
    assign rd_data_b = rd_data[1];
endmodule

// File: rtl/rf_checker.sv
module rf_checker #(
    parameter int DATA_W = 64,
    parameter int ID_W   = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [ID_W-1:0]   rd_id_a,
    input logic [DATA_W-1:0] rd_data_a,
    input logic [ID_W-1:0]   rd_id_b,
    input logic [DATA_W-1:0] rd_data_b,
    input logic [ID_W-1:0]   wr_id_a,
    input logic [DATA_W-1:0] wr_data_a,
    input logic [ID_W-1:0]   wr_id_b,
    input logic [DATA_W-1:0] wr_data_b
);
    localparam logic [ID_W-1:0] NULL_ID = {ID_W{1'b1}};

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (rd_data_a == '0 && rd_data_b == '0)); // R1

    AST_PORTS_AGREE: assert property (@(posedge clk) disable iff (rst)
        (rd_id_a == rd_id_b) |-> (rd_data_a == rd_data_b)); // R2

    AST_NULL_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_id_a == NULL_ID) |-> (rd_data_a == '0)); // R3

    AST_WRITE_A_LANDS: assert property (@(posedge clk) disable iff (rst)
        (wr_id_a != NULL_ID && wr_id_a != wr_id_b) ##1 (rd_id_a == $past(wr_id_a))
        |-> (rd_data_a == $past(wr_data_a))); // R4

    AST_WRITE_B_LANDS: assert property (@(posedge clk) disable iff (rst)
        (wr_id_b != NULL_ID) ##1 (rd_id_b == $past(wr_id_b))
        |-> (rd_data_b == $past(wr_data_b))); // R5

    AST_COLLIDE_B_WINS: assert property (@(posedge clk) disable iff (rst)
        (wr_id_a == wr_id_b && wr_id_b != NULL_ID) ##1 (rd_id_a == $past(wr_id_a))
        |-> (rd_data_a == $past(wr_data_b))); // R7

    AST_NULL_WRITE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (wr_id_a == NULL_ID && wr_id_b == NULL_ID) ##1 (rd_id_a == $past(rd_id_a))
        |-> $stable(rd_data_a)); // R6
endmodule

bind dual_wr_regfile rf_checker #(.DATA_W(DATA_W), .ID_W(ID_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rd_id_a   (rd_id_a),
    .rd_data_a (rd_data_a),
    .rd_id_b   (rd_id_b),
    .rd_data_b (rd_data_b),
    .wr_id_a   (wr_id_a),
    .wr_data_a (wr_data_a),
    .wr_id_b   (wr_id_b),
    .wr_data_b (wr_data_b)
);

// File: tb/sim_dual_wr_regfile.sv
`timescale 1ns/1ps
module sim_dual_wr_regfile;
    localparam int DW = 64;
    localparam int IW = 4;
    localparam logic [IW-1:0] NID = 4'hF;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [IW-1:0] rd_id_a = '0, rd_id_b = '0, wr_id_a = NID, wr_id_b = NID;
    logic [DW-1:0] rd_data_a, rd_data_b, wr_data_a = '0, wr_data_b = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [DW-1:0] model [15];

    always #10 clk = ~clk; // 50 MHz

    dual_wr_regfile u0 (
        .clk(clk), .rst(rst),
        .rd_id_a(rd_id_a), .rd_data_a(rd_data_a),
        .rd_id_b(rd_id_b), .rd_data_b(rd_data_b),
        .wr_id_a(wr_id_a), .wr_data_a(wr_data_a),
        .wr_id_b(wr_id_b), .wr_data_b(wr_data_b)
    );

    function automatic logic [DW-1:0] expv(input logic [IW-1:0] id);
        return (id == NID) ? '0 : model[id];
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Read every ID on both ports, port B in reverse order
    task automatic sweep_all(input string req);
        for (int i = 0; i < 16; i++) begin
            rd_id_a = IW'(i);
            rd_id_b = IW'(15 - i);
            #1;
            check(req, rd_data_a, expv(IW'(i)));
            check(req, rd_data_b, expv(IW'(15 - i)));
        end
    endtask

    // Called just after a falling edge
    task automatic do_write(input logic [IW-1:0] wa, input logic [DW-1:0] da,
                            input logic [IW-1:0] wb, input logic [DW-1:0] db);
        wr_id_a = wa; wr_data_a = da;
        wr_id_b = wb; wr_data_b = db;
        rd_id_a = wa; rd_id_b = wb;
        #1;
        check("R4 pre-edge old value", rd_data_a, expv(wa));
        check("R5 pre-edge old value", rd_data_b, expv(wb));
        @(posedge clk);
        if (wa != NID) model[wa] = da;
        if (wb != NID) model[wb] = db;   // R7: port B applied last
        @(negedge clk);
        wr_id_a = NID; wr_id_b = NID;
        #1;
        if (wa == wb && wa != NID)
            check("R7 collision port B wins", rd_data_a, db);
        else if (wa == NID)
            check("R3 R6 null target reads zero", rd_data_a, '0);
        else
            check("R4 port A write visible", rd_data_a, expv(wa));
        check("R5 port B write visible", rd_data_b, expv(wb));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int k = 0;
        for (int i = 0; i < 15; i++) model[i] = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        sweep_all("R1 R3 reset state");

        // Every ordered pair of write IDs, including the null ID
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                k++;
                do_write(IW'(a), {16'hA000 | 16'(a << 4 | b), 16'h1111, 32'(k)},
                         IW'(b), {16'hB000 | 16'(a << 4 | b), 16'h2222, 32'(k * 7)});
            end
            sweep_all("R8 other registers untouched");
        end

        // Both ports null for several cycles
        for (int n = 0; n < 3; n++) do_write(NID, 64'hDEAD_0000_0000_0001, NID, 64'hDEAD_0000_0000_0002);
        sweep_all("R6 null writes change nothing");

        // Register 0x4 written by both ports, then by A alone
        do_write(4'h4, 64'h1234_5678_9ABC_DEF0, 4'h4, 64'h0FED_CBA9_8765_4321);
        do_write(4'h4, 64'h5555_AAAA_5555_AAAA, NID, '0);
        sweep_all("R2 combinational reads");

        // Reset with writes pending: writes discarded
        wr_id_a = 4'h3; wr_data_a = '1;
        wr_id_b = 4'h9; wr_data_b = '1;
        rst = 1'b1;
        @(posedge clk);
        for (int i = 0; i < 15; i++) model[i] = '0;
        @(negedge clk);
        rst = 1'b0;
        wr_id_a = NID; wr_id_b = NID;
        sweep_all("R1 reset clears and drops writes");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule